// File: doc/BRIEF.md
# DMA Page Register Address Generator

This block extends the 16-bit per-channel address of a four-channel DMA engine into a 31-bit physical address. Each channel owns one low page byte and one high page byte. Software writes and reads these bytes over an 8-bit register bus. The channel is chosen by a 3-bit offset, and the mapping from offset to channel is sparse and not in order. Four of the eight offsets select a channel. The other four select none: a write to one of them is dropped and a read from one of them returns zero.

When a transfer engine needs a start address, it gives the channel, the channel's current address, a position within the transfer, a length and the direction bit. It then pulses a compute strobe. The block joins the channel's two page bytes with the current address to form a base. It then moves forward from the base by the position, or backward by the position plus the length. The result is registered and appears one cycle after the strobe, together with a valid flag. A parameter can leave the high page file out. In that case its reads return zero and it adds nothing to the address.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After reset, every page byte in both files reads as 0x00 and `phys_valid` is low.
- R2: Offsets map to channels as follows: offset 7 to channel 0, offset 3 to channel 1, offset 1 to channel 2 and offset 2 to channel 3. A byte written at one of these offsets reads back at the same offset.
- R3: Offsets 0, 4, 5 and 6 select no channel. A write to one of them changes no page byte, and a read from one of them returns 0x00.
- R4: The low file (`reg_sel_high`=0) and the high file (`reg_sel_high`=1) are independent. A write to one file leaves every byte of the other file unchanged.
- R5: The base address is {high page bits 6:0, low page byte, `cur_addr`}: the high page byte sits in bits 30:24, the low page byte in bits 23:16 and `cur_addr` in bits 15:0. Bit 7 of the high page is ignored.
- R6: With `mode_dec`=0, `phys_addr` equals base + `xfer_pos`, taken modulo 2^31.
- R7: With `mode_dec`=1, `phys_addr` equals base - `xfer_pos` - `xfer_len`, taken modulo 2^31.
- R8: `phys_valid` is high exactly in the cycle after a cycle with `calc_go` high. In a cycle with no strobe, `phys_addr` holds its previous value.
- R9: When `HIGH_EN`=0, reads from the high file return 0x00 and the high page contributes 0 to the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Page register write strobe |
| reg_sel_high | input | 1 | Selects the file: 0 for the low page file, 1 for the high page file |
| reg_off | input | 3 | Page register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel_high`/`reg_off`, combinational |
| calc_go | input | 1 | Compute strobe |
| calc_chan | input | 2 | Channel whose pages are used |
| cur_addr | input | 16 | Current address of the channel |
| xfer_pos | input | 17 | Position within the transfer |
| xfer_len | input | 17 | Length of the requested span |
| mode_dec | input | 1 | 1 selects decrementing addressing |
| phys_addr | output | 31 | Registered physical start address |
| phys_valid | output | 1 | High for one cycle, when `phys_addr` is new |

## Verification
A page byte stored at the wrong channel shows up right away at the register port, since the bench reads every offset back after each write. The same fault also puts a wrong value in bits 30:16 of the address one cycle after the next strobe. An arithmetic fault shows only in `phys_addr`, one cycle after the strobe. The bench therefore checks every channel in both directions, with values chosen to wrap around past zero and past the top of the 31-bit space. A stray or missing valid pulse is caught in the cycle it happens, by assertions and by the bench checking that the output holds between strobes.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int CHANS  = 4;
  localparam int CHAN_W = 2;
  localparam int OFF_W  = 3;

  typedef struct packed {
    logic              hit;
    logic [CHAN_W-1:0] chan;
  } port_hit_t;

  // Sparse offset-to-channel map.
  function automatic port_hit_t decode_port(input logic [OFF_W-1:0] off);
    port_hit_t r;
    r.hit  = 1'b1;
    r.chan = '0;
    case (off)
      3'd7:    r.chan = 2'd0;
      3'd3:    r.chan = 2'd1;
      3'd1:    r.chan = 2'd2;
      3'd2:    r.chan = 2'd3;
      default: r.hit  = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dpa_port_decode.sv
module dpa_port_decode
  import dpa_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  output logic              off_valid,
  output logic [CHAN_W-1:0] off_chan
);
  port_hit_t hit_w;

  always_comb begin
    hit_w     = decode_port(off);
    off_valid = hit_w.hit;
    off_chan  = hit_w.chan;
  end
endmodule

// File: rtl/dpa_page_file.sv
module dpa_page_file #(
  parameter int CHANS     = 4,
  parameter int PAGE_W    = 8,
  parameter bit IMPLEMENT = 1'b1,
  localparam int CHAN_W   = $clog2(CHANS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CHAN_W-1:0]       wr_chan,
  input  logic [PAGE_W-1:0]       wr_data,
  input  logic [CHAN_W-1:0]       rd_chan,
  output logic [PAGE_W-1:0]       rd_data,
  input  logic [CHAN_W-1:0]       sel_chan,
  output logic [PAGE_W-1:0]       sel_page,
  output logic [CHANS*PAGE_W-1:0] pages_flat
);
  logic [PAGE_W-1:0] page_q [CHANS];

  generate
    if (IMPLEMENT) begin : g_regs
      for (genvar c = 0; c < CHANS; c++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            page_q[c] <= '0;
          else if (wr_en && (wr_chan == CHAN_W'(c)))
            page_q[c] <= wr_data;
        end
      end
    end else begin : g_absent
      for (genvar c = 0; c < CHANS; c++) begin : g_chan
        assign page_q[c] = '0;
      end
      logic unused_wr;
      assign unused_wr = ^{wr_en, wr_chan, wr_data, clk, rst_n};
    end
  endgenerate

  generate
    for (genvar c = 0; c < CHANS; c++) begin : g_flat
      assign pages_flat[c*PAGE_W +: PAGE_W] = page_q[c];
    end
  endgenerate

  assign rd_data  = page_q[rd_chan];
  assign sel_page = page_q[sel_chan];
endmodule

// File: rtl/dpa_addr_calc.sv
module dpa_addr_calc #(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 17,
  parameter int PAGE_W  = 8,
  parameter int HI_BITS = 7,
  localparam int PHYS_W = HI_BITS + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PAGE_W-1:0] lo_page,
  input  logic [PAGE_W-1:0] hi_page,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  pos,
  input  logic [CNT_W-1:0]  len,
  input  logic              dec,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              phys_valid,
  output logic [PHYS_W-1:0] start_addr
);
  function automatic logic [PHYS_W-1:0] make_base(
      input logic [PAGE_W-1:0] hi, input logic [PAGE_W-1:0] lo,
      input logic [ADDR_W-1:0] a);
    return {hi[HI_BITS-1:0], lo, a};
  endfunction

  function automatic logic [PHYS_W-1:0] widen(input logic [CNT_W-1:0] v);
    return {{(PHYS_W-CNT_W){1'b0}}, v};
  endfunction

  function automatic logic [PHYS_W-1:0] step_addr(
      input logic [PHYS_W-1:0] base, input logic [CNT_W-1:0] p,
      input logic [CNT_W-1:0] l, input logic down);
    if (down) return base - widen(p) - widen(l);
    else      return base + widen(p);
  endfunction

  logic [PHYS_W-1:0] base_w;
  logic unused_hi;

  assign unused_hi  = ^hi_page[PAGE_W-1:HI_BITS];
  assign base_w     = make_base(hi_page, lo_page, cur_addr);
  assign start_addr = step_addr(base_w, pos, len, dec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr  <= '0;
      phys_valid <= 1'b0;
    end else begin
      phys_valid <= go;
      if (go) phys_addr <= start_addr;
    end
  end
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dpa_pkg::*;
#(
  parameter bit HIGH_EN = 1'b1,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 17,
  parameter int PAGE_W  = 8,
  parameter int HI_BITS = 7,
  localparam int PHYS_W = HI_BITS + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel_high,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  input  logic              calc_go,
  input  logic [CHAN_W-1:0] calc_chan,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  xfer_pos,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic              mode_dec,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              phys_valid
);
  logic                    off_valid;
  logic [CHAN_W-1:0]       off_chan;
  logic                    lo_wr_en, hi_wr_en;
  logic [PAGE_W-1:0]       lo_rd, hi_rd, lo_sel, hi_sel;
  logic [CHANS*PAGE_W-1:0] lo_flat, hi_flat;
  logic [PHYS_W-1:0]       start_addr;

  dpa_port_decode u_decode (
    .off       (reg_off),
    .off_valid (off_valid),
    .off_chan  (off_chan)
  );

  assign lo_wr_en = reg_wr && off_valid && !reg_sel_high;
  assign hi_wr_en = reg_wr && off_valid &&  reg_sel_high;

  dpa_page_file #(.CHANS(CHANS), .PAGE_W(PAGE_W), .IMPLEMENT(1'b1)) u_lo_file (
    .clk(clk), .rst_n(rst_n), .wr_en(lo_wr_en), .wr_chan(off_chan),
    .wr_data(reg_wdata), .rd_chan(off_chan), .rd_data(lo_rd),
    .sel_chan(calc_chan), .sel_page(lo_sel), .pages_flat(lo_flat)
  );

  dpa_page_file #(.CHANS(CHANS), .PAGE_W(PAGE_W), .IMPLEMENT(HIGH_EN)) u_hi_file (
    .clk(clk), .rst_n(rst_n), .wr_en(hi_wr_en), .wr_chan(off_chan),
    .wr_data(reg_wdata), .rd_chan(off_chan), .rd_data(hi_rd),
    .sel_chan(calc_chan), .sel_page(hi_sel), .pages_flat(hi_flat)
  );

  always_comb begin
    reg_rdata = '0;
    if (off_valid) reg_rdata = reg_sel_high ? hi_rd : lo_rd;
  end

  dpa_addr_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W),
                  .HI_BITS(HI_BITS)) u_calc (
    .clk(clk), .rst_n(rst_n), .go(calc_go),
    .lo_page(lo_sel), .hi_page(hi_sel), .cur_addr(cur_addr),
    .pos(xfer_pos), .len(xfer_len), .dec(mode_dec),
    .phys_addr(phys_addr), .phys_valid(phys_valid), .start_addr(start_addr)
  );
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter bit HIGH_EN = 1'b1,
  parameter int PAGE_W  = 8,
  parameter int PHYS_W  = 31,
  parameter int FLAT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_sel_high,
  input logic [PAGE_W-1:0] reg_rdata,
  input logic              calc_go,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              phys_valid,
  input logic              off_valid,
  input logic [FLAT_W-1:0] lo_flat,
  input logic [FLAT_W-1:0] hi_flat
);
  AST_VALID_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    calc_go |=> phys_valid); // R8
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_go |=> !phys_valid); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_go |=> $stable(phys_addr)); // R8
  AST_BAD_PORT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !off_valid |-> (reg_rdata == '0)); // R3
  AST_BAD_PORT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !off_valid) |=> ($stable(lo_flat) && $stable(hi_flat))); // R3
  AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel_high) |=> $stable(hi_flat)); // R4
  AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel_high) |=> $stable(lo_flat)); // R4
  AST_ABSENT_HIGH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_high && !HIGH_EN) |-> (reg_rdata == '0)); // R9
endmodule

bind dma_page_addr_gen dpa_checker #(
  .HIGH_EN(HIGH_EN), .PAGE_W(PAGE_W), .PHYS_W(PHYS_W),
  .FLAT_W(dpa_pkg::CHANS*PAGE_W)
) u_dpa_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel_high(reg_sel_high),
  .reg_rdata(reg_rdata), .calc_go(calc_go), .phys_addr(phys_addr),
  .phys_valid(phys_valid), .off_valid(off_valid),
  .lo_flat(lo_flat), .hi_flat(hi_flat)
);

// File: tb/test_dma_page_addr_gen.sv
module test_dma_page_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel_high = 1'b0;
  logic [2:0]  reg_off = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  rdata_a, rdata_b;
  logic        calc_go = 1'b0, mode_dec = 1'b0;
  logic [1:0]  calc_chan = '0;
  logic [15:0] cur_addr = '0;
  logic [16:0] xfer_pos = '0, xfer_len = '0;
  logic [30:0] paddr_a, paddr_b;
  logic        pvalid_a, pvalid_b;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] lo_m [4];
  logic [7:0] hi_m [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_addr_gen #(.HIGH_EN(1'b1)) i_dma_page_addr_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel_high(reg_sel_high),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
    .calc_go(calc_go), .calc_chan(calc_chan), .cur_addr(cur_addr),
    .xfer_pos(xfer_pos), .xfer_len(xfer_len), .mode_dec(mode_dec),
    .phys_addr(paddr_a), .phys_valid(pvalid_a));

  dma_page_addr_gen #(.HIGH_EN(1'b0)) i_dma_page_addr_gen_nohigh (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel_high(reg_sel_high),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
    .calc_go(calc_go), .calc_chan(calc_chan), .cur_addr(cur_addr),
    .xfer_pos(xfer_pos), .xfer_len(xfer_len), .mode_dec(mode_dec),
    .phys_addr(paddr_b), .phys_valid(pvalid_b));

  // Bench's own view of the offset map (R2/R3): returns -1 for no channel.
  function automatic int chan_for(input int off);
    if (off == 7) return 0;
    if (off == 3) return 1;
    if (off == 1) return 2;
    if (off == 2) return 3;
    return -1;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_page(input bit hi, input int off, input logic [7:0] v);
    int ch;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel_high = hi; reg_off = 3'(off); reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    ch = chan_for(off);
    if (ch >= 0) begin
      if (hi) hi_m[ch] = v; else lo_m[ch] = v;
    end
  endtask

  task automatic read_all(input string req);
    for (int h = 0; h < 2; h++) begin
      for (int o = 0; o < 8; o++) begin
        int ch;
        logic [7:0] exp_a, exp_b;
        reg_sel_high = h[0]; reg_off = 3'(o);
        #1;
        ch = chan_for(o);
        exp_a = (ch < 0) ? 8'h00 : (h == 1 ? hi_m[ch] : lo_m[ch]);
        exp_b = (ch < 0 || h == 1) ? 8'h00 : lo_m[ch];
        check(req, rdata_a, exp_a);
        check({req, " R9"}, rdata_b, exp_b);
      end
    end
  endtask

  function automatic logic [30:0] expect_addr(input logic [7:0] hp, input logic [7:0] lp,
      input logic [15:0] a, input logic [16:0] p, input logic [16:0] l, input bit dn);
    longint base, r;
    base = (longint'(hp & 8'h7f) * 64'h100_0000) + (longint'(lp) * 64'h1_0000) + longint'(a);
    r = dn ? (base - longint'(p) - longint'(l)) : (base + longint'(p));
    return 31'(r & 64'h7fff_ffff);
  endfunction

  task automatic run_calc(input int ch, input logic [15:0] a, input logic [16:0] p,
                          input logic [16:0] l, input bit dn);
    logic [30:0] ea, eb;
    string req;
    req = dn ? "R7/R5" : "R6/R5";
    @(negedge clk);
    calc_go = 1'b1; calc_chan = 2'(ch); cur_addr = a;
    xfer_pos = p; xfer_len = l; mode_dec = dn;
    @(negedge clk);
    calc_go = 1'b0;
    ea = expect_addr(hi_m[ch], lo_m[ch], a, p, l, dn);
    eb = expect_addr(8'h00, lo_m[ch], a, p, l, dn);
    check("R8 valid after strobe", pvalid_a, 1);
    check(req, paddr_a, ea);
    check({req, " R9"}, paddr_b, eb);
    cur_addr = ~a; xfer_pos = ~p; mode_dec = ~dn;
    @(negedge clk);
    check("R8 valid drops", pvalid_a, 0);
    check("R8 address held", paddr_a, ea);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin lo_m[c] = 8'h00; hi_m[c] = 8'h00; end
    repeat (3) @(negedge clk);
    check("R1 valid at reset", pvalid_a, 0);
    read_all("R1 reset pages");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", pvalid_a, 0);

    // R2/R3/R4: write every offset of both files, read back everything.
    for (int h = 0; h < 2; h++) begin
      for (int o = 0; o < 8; o++) begin
        write_page(h[0], o, 8'(8'h5A ^ (o * 8'h13) ^ (h * 8'hC0)));
        read_all("R2/R3/R4 page map");
      end
    end

    // R5-R7 and R9: distinct pages, high bit 7 set on some channels.
    for (int c = 0; c < 4; c++) begin
      int offs [4] = '{7, 3, 1, 2};
      write_page(1'b0, offs[c], 8'(8'h21 + c * 8'h31));
      write_page(1'b1, offs[c], 8'(8'h85 + c * 8'h17));
    end
    read_all("R2 final pages");
    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        run_calc(c, 16'h0000, 17'h00000, 17'h00000, d[0]);
        run_calc(c, 16'hFFFF, 17'h00001, 17'h00000, d[0]);
        run_calc(c, 16'h1234, 17'h00010, 17'h00020, d[0]);
        run_calc(c, 16'h8001, 17'h1FFFF, 17'h10000, d[0]);
      end
    end

    // Wrap at both ends of the 31-bit space.
    write_page(1'b0, 7, 8'h00);
    write_page(1'b1, 7, 8'h00);
    run_calc(0, 16'h0000, 17'h00001, 17'h00000, 1'b1);
    run_calc(0, 16'h0000, 17'h00000, 17'h00001, 1'b1);
    write_page(1'b0, 7, 8'hFF);
    write_page(1'b1, 7, 8'hFF);
    run_calc(0, 16'hFFFF, 17'h00001, 17'h00000, 1'b0);
    run_calc(0, 16'hFFF0, 17'h1FFFF, 17'h00000, 1'b0);

    // R8: back-to-back strobes.
    @(negedge clk);
    calc_go = 1'b1; calc_chan = 2'd3; cur_addr = 16'h0100;
    xfer_pos = 17'h4; xfer_len = 17'h0; mode_dec = 1'b0;
    @(negedge clk);
    check("R8 first of pair", paddr_a, expect_addr(hi_m[3], lo_m[3], 16'h0100, 17'h4, 17'h0, 1'b0));
    calc_chan = 2'd2; mode_dec = 1'b1; xfer_len = 17'h8;
    @(negedge clk);
    calc_go = 1'b0;
    check("R8 valid stays high", pvalid_a, 1);
    check("R8 second of pair", paddr_a, expect_addr(hi_m[2], lo_m[2], 16'h0100, 17'h4, 17'h8, 1'b1));
    @(negedge clk);
    check("R8 valid ends", pvalid_a, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule